// File: doc/BRIEF.md
# Dual-Group ADC Conversion Sequencer

This block runs continuous conversions for two independent converter groups. Each group has two converters that always start together. A register-write path supplies start and stop requests for each group. These requests act only when the commit strobe marks the end of the write frame. An internal counter splits time into conversion periods of `osr_i` clocks. At the end of each period the block samples the decimation filter's output word for that group. The filter itself is outside the block. The block also drives the filter reset, a one-cycle valid strobe, an active-low data-ready flag, a stop-pending status bit and a held result register.

After every start or restart, the first two periods are hidden while the filter settles. A stop lets the period in progress finish, and after that the filter stays in reset. The last result stays readable until it is overwritten, until the group is disabled, or until standby is requested.

Data flows in one direction only and there is no back-pressure. `conv_data_i` is sampled in the cycle where `period_tick_o` is high, and the filter cannot be stalled. On the output side, `drdy_n_o` low together with `result_o` forms the offer, and `rd_ack_i` is the host's acknowledge. A result the host has not read is overwritten by the next one, which the host cannot refuse. `osr_i` must be at least 1 and must stay stable while any group runs.

Top module: `dual_conv_seq`

## Requirements
- R1: A start request acts only in a cycle with `commit_i` high and the group enabled. It sets that group running and drops its `filt_rst_o`. The other group is not affected.
- R2: A committed start on a running group aborts the current period. The next `period_tick_o` comes exactly `osr_i` cycles after the commit cycle.
- R3: When start and stop are committed together, start wins. The group runs and `stop_pend_o` stays 0.
- R4: A committed stop on a running group sets `stop_pend_o` in the next cycle. The current period still completes, and at its tick the group halts, `filt_rst_o` rises and `stop_pend_o` clears. A stop committed while the group is idle is ignored.
- R5: After a start, the first two ticks produce no `res_valid_o`. From the third tick on, every tick raises `res_valid_o` for one cycle in the next cycle and loads `result_o` with the sampled `conv_data_i`.
- R6: `drdy_n_o` goes low together with `res_valid_o`. It returns high on `rd_ack_i` or on a committed start. A new result wins over an acknowledge given in the same cycle.
- R7: `result_o` keeps its value after a stop and across starts. It is cleared to 0 only by reset, by a low `enable_i`, or by `standby_i`.
- R8: A low `enable_i` or a high `standby_i` halts the group in the next cycle and clears `stop_pend_o`.
- R9: While a group runs, `period_tick_o` is high in one cycle of every `osr_i` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osr_i | input | CW | Period length in clocks (1 or more) |
| commit_i | input | 1 | End of register-write frame; qualifies start and stop |
| start_i | input | NGRP | Per-group start request |
| stop_i | input | NGRP | Per-group stop request |
| enable_i | input | NGRP | Per-group enable; low clears the group |
| standby_i | input | 1 | Clears all groups while high |
| rd_ack_i | input | NGRP | Host acknowledge of a result |
| conv_data_i | input | NGRP*2*DW | Filter output, two converters per group |
| period_tick_o | output | NGRP | End of conversion period |
| filt_rst_o | output | NGRP | Filter held in reset |
| res_valid_o | output | NGRP | One-cycle new-result strobe |
| drdy_n_o | output | NGRP | Active-low data ready |
| stop_pend_o | output | NGRP | Stop requested, not yet halted |
| result_o | output | NGRP*2*DW | Held results, two converters per group |

## Verification
A wrong settle count shows up at the ports within three periods of a start: a valid strobe comes one period early or late, and `result_o` changes at the wrong point. A stuck stop-pending state shows as `filt_rst_o` failing to rise at the first tick after the stop, or as `stop_pend_o` staying high past that tick. A counter that is not restarted by an abort shifts every later tick, so the first tick after the restart is already out of place. The bench compares every output against a cycle model in every cycle, so each such fault is reported in the cycle it first shows.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } grp_st_t;

  localparam int unsigned SETTLE_HIDE = 2;
endpackage

// File: rtl/seq_period_ctr.sv
module seq_period_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic [CW-1:0] osr_i,
  output logic          tick_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && !restart_i && (cnt_q == osr_i - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (!run_i || restart_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + ONE;
  end

  // R2: an abort restarts the period count
  p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
  // R9: count stays inside the period while running
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $stable(osr_i) && osr_i != '0) |-> (cnt_q < osr_i));
endmodule

// File: rtl/seq_grp_ctrl.sv
module seq_grp_ctrl
  import seq_pkg::*;
#(
  parameter int unsigned RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          standby_i,
  input  logic          start_cmd_i,
  input  logic          stop_cmd_i,
  input  logic          ack_i,
  input  logic          tick_i,
  input  logic [RW-1:0] data_i,
  output logic          run_o,
  output logic          restart_o,
  output logic          filt_rst_o,
  output logic          valid_o,
  output logic          drdy_n_o,
  output logic          pend_o,
  output logic [RW-1:0] res_o
);
  grp_st_t     st_q;
  logic [1:0]  settle_q;
  logic        clear;

  assign clear      = !enable_i || standby_i;
  assign restart_o  = !clear && start_cmd_i;
  assign run_o      = (st_q == ST_RUN);
  assign filt_rst_o = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      settle_q <= '0;
      pend_o   <= 1'b0;
      drdy_n_o <= 1'b1;
      res_o    <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clear) begin
        st_q     <= ST_IDLE;
        settle_q <= '0;
        pend_o   <= 1'b0;
        drdy_n_o <= 1'b1;
        res_o    <= '0;
      end else if (start_cmd_i) begin
        st_q     <= ST_RUN;
        settle_q <= '0;
        pend_o   <= 1'b0;
        drdy_n_o <= 1'b1;
      end else begin
        if (stop_cmd_i && st_q == ST_RUN) pend_o <= 1'b1;
        if (ack_i) drdy_n_o <= 1'b1;
        if (tick_i) begin
          if (settle_q == 2'(SETTLE_HIDE)) begin
            res_o    <= data_i;
            valid_o  <= 1'b1;
            drdy_n_o <= 1'b0;
          end else begin
            settle_q <= settle_q + 2'd1;
          end
          if (pend_o || stop_cmd_i) begin
            st_q     <= ST_IDLE;
            pend_o   <= 1'b0;
            settle_q <= '0;
          end
        end
      end
    end
  end

  // R5: a result only follows a period end
  p_valid_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(tick_i));
  // R6: a fresh result always shows as ready
  p_valid_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !drdy_n_o);
  // R3: start beats stop and clears ready
  p_start_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> (!pend_o && drdy_n_o && run_o));
  // R4: pending stop only while running
  p_pend_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |-> run_o);
  // R7 / R8: clear empties the group
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (res_o == '0 && !pend_o && filt_rst_o));
endmodule

// File: rtl/dual_conv_seq.sv
module dual_conv_seq #(
  parameter int unsigned NGRP = 2,
  parameter int unsigned DW   = 8,
  parameter int unsigned CW   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CW-1:0]          osr_i,
  input  logic                   commit_i,
  input  logic [NGRP-1:0]        start_i,
  input  logic [NGRP-1:0]        stop_i,
  input  logic [NGRP-1:0]        enable_i,
  input  logic                   standby_i,
  input  logic [NGRP-1:0]        rd_ack_i,
  input  logic [NGRP*2*DW-1:0]   conv_data_i,
  output logic [NGRP-1:0]        period_tick_o,
  output logic [NGRP-1:0]        filt_rst_o,
  output logic [NGRP-1:0]        res_valid_o,
  output logic [NGRP-1:0]        drdy_n_o,
  output logic [NGRP-1:0]        stop_pend_o,
  output logic [NGRP*2*DW-1:0]   result_o
);
  localparam int unsigned RW = 2 * DW;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic run, restart, tick;

    seq_period_ctr #(.CW(CW)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .restart_i (restart),
      .osr_i     (osr_i),
      .tick_o    (tick)
    );

    seq_grp_ctrl #(.RW(RW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable_i    (enable_i[g]),
      .standby_i   (standby_i),
      .start_cmd_i (commit_i && start_i[g]),
      .stop_cmd_i  (commit_i && stop_i[g]),
      .ack_i       (rd_ack_i[g]),
      .tick_i      (tick),
      .data_i      (conv_data_i[g*RW +: RW]),
      .run_o       (run),
      .restart_o   (restart),
      .filt_rst_o  (filt_rst_o[g]),
      .valid_o     (res_valid_o[g]),
      .drdy_n_o    (drdy_n_o[g]),
      .pend_o      (stop_pend_o[g]),
      .res_o       (result_o[g*RW +: RW])
    );

    assign period_tick_o[g] = tick;

    // R1: a tick never comes from a halted group
    p_tick_running_r1: assert property (@(posedge clk) disable iff (!rst_n)
      period_tick_o[g] |-> !filt_rst_o[g]);
  end
endmodule

// File: tb/test_dual_conv_seq.sv
module test_dual_conv_seq;
  localparam int NGRP = 2, DW = 8, CW = 8, RW = 2 * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] osr = 8'd3;
  logic commit = 1'b0, standby = 1'b0;
  logic [NGRP-1:0] start = '0, stop = '0, en = '0, ack = '0;
  logic [NGRP*RW-1:0] data = '0;
  logic [NGRP-1:0] tick, frst, vld, drdy_n, pend;
  logic [NGRP*RW-1:0] res;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model state
  bit m_run[NGRP], m_pend[NGRP], m_val[NGRP], m_drdy[NGRP];
  int m_cnt[NGRP], m_set[NGRP];
  logic [RW-1:0] m_res[NGRP];

  always #10 clk = ~clk;

  dual_conv_seq #(.NGRP(NGRP), .DW(DW), .CW(CW)) i_dual_conv_seq (
    .clk(clk), .rst_n(rst_n), .osr_i(osr), .commit_i(commit),
    .start_i(start), .stop_i(stop), .enable_i(en), .standby_i(standby),
    .rd_ack_i(ack), .conv_data_i(data), .period_tick_o(tick),
    .filt_rst_o(frst), .res_valid_o(vld), .drdy_n_o(drdy_n),
    .stop_pend_o(pend), .result_o(res)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit f_clr(int g);
    return !en[g] || standby;
  endfunction

  function automatic bit f_tick(int g);
    bit rs = commit && start[g] && !f_clr(g);
    return m_run[g] && !rs && (m_cnt[g] == int'(osr) - 1);
  endfunction

  task automatic model_reset();
    for (int g = 0; g < NGRP; g++) begin
      m_run[g] = 0; m_pend[g] = 0; m_val[g] = 0; m_drdy[g] = 1;
      m_cnt[g] = 0; m_set[g] = 0; m_res[g] = '0;
    end
  endtask

  task automatic model_step();
    for (int g = 0; g < NGRP; g++) begin
      bit tk = f_tick(g);
      bit sc = commit && start[g];
      bit pc = commit && stop[g];
      bit rs = sc && !f_clr(g);
      bit was_run = m_run[g];
      m_cnt[g] = (!was_run || rs || tk) ? 0 : m_cnt[g] + 1;
      m_val[g] = 0;
      if (f_clr(g)) begin
        m_run[g] = 0; m_set[g] = 0; m_pend[g] = 0; m_drdy[g] = 1; m_res[g] = '0;
      end else if (sc) begin
        m_run[g] = 1; m_set[g] = 0; m_pend[g] = 0; m_drdy[g] = 1;
      end else begin
        bit old_pend = m_pend[g];
        if (pc && was_run) m_pend[g] = 1;
        if (ack[g]) m_drdy[g] = 1;
        if (tk) begin
          if (m_set[g] == 2) begin
            m_res[g] = data[g*RW +: RW]; m_val[g] = 1; m_drdy[g] = 0;
          end else m_set[g]++;
          if (old_pend || pc) begin
            m_run[g] = 0; m_pend[g] = 0; m_set[g] = 0;
          end
        end
      end
    end
  endtask

  task automatic check_outputs();
    for (int g = 0; g < NGRP; g++) begin
      chk("R1/R4/R8 filt_rst", 32'(frst[g]), 32'(!m_run[g]));
      chk("R4 stop_pend", 32'(pend[g]), 32'(m_pend[g]));
      chk("R5 res_valid", 32'(vld[g]), 32'(m_val[g]));
      chk("R6 drdy_n", 32'(drdy_n[g]), 32'(m_drdy[g]));
      chk("R7 result", 32'(res[g*RW +: RW]), 32'(m_res[g]));
    end
  endtask

  task automatic check_tick();
    for (int g = 0; g < NGRP; g++)
      chk("R2/R9 period_tick", 32'(tick[g]), 32'(f_tick(g)));
  endtask

  // one cycle: inputs already driven at negedge
  task automatic cycle();
    #1 check_tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic idle_inputs();
    commit = 0; start = '0; stop = '0; ack = '0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en = '1;
    // reset state (R7, R8)
    for (int g = 0; g < NGRP; g++) begin
      chk("R8 reset filt_rst", 32'(frst[g]), 32'd1);
      chk("R7 reset result", 32'(res[g*RW +: RW]), 32'd0);
      chk("R6 reset drdy_n", 32'(drdy_n[g]), 32'd1);
    end
    // R1: start without commit is ignored
    start = 2'b11; cycle(); idle_inputs();
    chk("R1 no commit no start", 32'(frst), 32'h3);
    // R4: stop while idle is ignored
    commit = 1; stop = 2'b11; cycle(); idle_inputs();
    chk("R4 idle stop ignored", 32'(pend), 32'h0);
    // R1: start group 0 only
    commit = 1; start = 2'b01; cycle(); idle_inputs();
    chk("R1 only group 0 runs", 32'(frst), 32'h2);
    // R3: start and stop together on group 1
    commit = 1; start = 2'b10; stop = 2'b10; cycle(); idle_inputs();
    chk("R3 start wins", 32'(pend[1]), 32'd0);
    chk("R3 group 1 running", 32'(frst[1]), 32'd0);
    // run long enough for settled results, including an R2 restart
    for (int i = 0; i < 20; i++) begin
      data = NGRP*RW'($urandom);
      if (i == 7) begin commit = 1; start = 2'b01; end
      cycle(); idle_inputs();
    end
    // random phases with different period lengths
    for (int ph = 0; ph < 10; ph++) begin
      en = '0; cycle();
      en = '1; osr = CW'(1 + ph % 5);
      for (int i = 0; i < 1500; i++) begin
        data = NGRP*RW'({$urandom, $urandom});
        if ($urandom_range(0, 7) == 0) begin
          commit = 1;
          start = NGRP'($urandom_range(0, 3) & ($urandom_range(0, 2) == 0 ? 3 : 0));
          stop  = NGRP'($urandom_range(0, 3));
        end
        ack = NGRP'($urandom_range(0, 3) & ($urandom_range(0, 3) == 0 ? 3 : 0));
        en[0] = ($urandom_range(0, 199) != 0);
        en[1] = ($urandom_range(0, 199) != 0);
        standby = ($urandom_range(0, 499) == 0);
        cycle(); idle_inputs(); standby = 0; en = '1;
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule